// File: doc/BRIEF.md
# Two-Domain Time-Sliced Link Scheduler

This block lets two security domains share one physical output link without either one being able to see the other's activity in its own timing. A high-confidentiality domain and a low-confidentiality domain each own a private flit buffer and a private pool of downstream credits. Link time is cut into a repeating frame of single-flit slots. Every slot belongs to exactly one domain for as long as the block is out of reset.

In each slot only the owning domain may send, and only when it has a buffered flit and at least one credit. A slot that its owner cannot use stays empty. It is never handed to the other domain. The block therefore does not conserve work, and the link bandwidth and latency that one domain sees are fixed by the frame map alone.

The slot map is sampled from an input while reset is held. A pair of counters reports how many owned slots each domain has left unused. Upstream producers use a valid/ready handshake per domain. The downstream side returns credits with one pulse per freed buffer entry.

Top module: `tdm_link_sched`

## Requirements
- R1: While and right after reset, `link_valid` is 0, both idle counters read 0 and both `hi_ready` and `lo_ready` are 1.
- R2: The slot index starts at 0 on the first cycle after reset, advances by one every cycle and wraps from FRAME-1 to 0. Slot s is owned by the low domain when bit s of the map captured during reset is 1, and by the high domain when it is 0.
- R3: A flit appears on the link only for the domain that owns the slot. `link_lo` is 1 for a low-domain flit and 0 for a high-domain flit.
- R4: When the owner of a slot has an empty buffer, that slot carries no flit, even if the other domain has flits waiting.
- R5: Each domain starts with CREDITS credits and spends one per flit sent. A pulse on its credit-return input gives one credit back. With zero credits the domain sends nothing in its slots.
- R6: Each domain's ready is 0 only when that domain's own buffer holds DEPTH flits. A full buffer in one domain never lowers the other domain's ready.
- R7: Within a domain, flits leave in the order in which they were accepted.
- R8: A domain's idle counter goes up by one for each of its owned slots that carries no flit, and it is never incremented in a slot it does not own.
- R9: The cycles at which low-domain flits are delivered are identical whether the high domain is silent or is flooding its input.
- R10: A flit granted in a slot is presented on `link_valid`/`link_lo`/`link_data` in the cycle that follows that slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset. The slot map is captured while it is high |
| slot_map | input | FRAME | Per-slot owner, where 1 means the low domain owns the slot |
| hi_valid | input | 1 | High-domain flit offered |
| hi_data | input | DATA_W | High-domain flit payload |
| hi_ready | output | 1 | High-domain buffer can accept |
| lo_valid | input | 1 | Low-domain flit offered |
| lo_data | input | DATA_W | Low-domain flit payload |
| lo_ready | output | 1 | Low-domain buffer can accept |
| hi_credit | input | 1 | One-cycle credit return for the high domain |
| lo_credit | input | 1 | One-cycle credit return for the low domain |
| link_valid | output | 1 | Link carries a flit this cycle |
| link_lo | output | 1 | Domain of the flit on the link (1 = low) |
| link_data | output | DATA_W | Flit payload on the link |
| hi_idle | output | IDLE_W | Count of unused high-domain slots |
| lo_idle | output | IDLE_W | Count of unused low-domain slots |

## Verification
The slot used on the cycle ending at the k-th clock edge after reset is k-1 mod FRAME. Its grant, link outputs and idle-counter step become visible just after edge k, so the bench's cycle model advances by exactly one slot per edge and compares the link and both counters on the following falling edge. A flit accepted at edge k can be granted no sooner than the slot after that edge. Credit pulses and ready levels take effect at the next edge. The non-interference check records the delivery cycle of every low-domain flit in two runs that differ only in high-domain load and compares the two lists entry by entry.

// File: rtl/tdm_pkg.sv
package tdm_pkg;

    localparam int NUM_DOM = 2;

    typedef enum logic {
        DOM_HI = 1'b0,
        DOM_LO = 1'b1
    } dom_e;

    typedef struct packed {
        logic valid;
        dom_e dom;
    } beat_hdr_t;

    function automatic int unsigned slot_after(input int unsigned idx, input int unsigned frame);
        return (idx == frame - 1) ? 0 : idx + 1;
    endfunction

endpackage

// File: rtl/tdm_vc_fifo.sv
module tdm_vc_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] rd_q, wr_q;
    logic [CW-1:0] cnt_q;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) begin
                mem[wr_q] <= din;
                wr_q      <= bump(wr_q);
            end
            if (pop) rd_q <= bump(rd_q);
            cnt_q <= cnt_q + CW'(push) - CW'(pop);
        end
    end

    assign dout  = mem[rd_q];
    assign full  = (cnt_q == CW'(DEPTH));
    assign empty = (cnt_q == '0);

    AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(DEPTH)); // R6
    AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (rst)
        pop |-> cnt_q != '0); // R7
endmodule

// File: rtl/tdm_slot_table.sv
module tdm_slot_table
    import tdm_pkg::*;
#(
    parameter int FRAME = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [FRAME-1:0] map_in,
    output dom_e             owner,
    output logic [$clog2(FRAME)-1:0] slot
);
    localparam int SW = $clog2(FRAME);

    logic [FRAME-1:0] map_q;
    logic [SW-1:0]    slot_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            map_q  <= map_in;
            slot_q <= '0;
        end else begin
            slot_q <= SW'(slot_after(int'(slot_q), FRAME));
        end
    end

    assign owner = map_q[slot_q] ? DOM_LO : DOM_HI;
    assign slot  = slot_q;

    AST_SLOT_WRAP: assert property (@(posedge clk) disable iff (rst)
        (slot_q == SW'(FRAME - 1)) |=> (slot_q == '0)); // R2
    AST_MAP_HELD: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $stable(map_q)); // R2
endmodule

// File: rtl/tdm_credit_ctr.sv
module tdm_credit_ctr #(
    parameter int MAX = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic take,
    input  logic ret,
    output logic ok
);
    localparam int CW = $clog2(MAX + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= CW'(MAX);
        else     cnt_q <= cnt_q - CW'(take) + CW'(ret);
    end

    assign ok = (cnt_q != '0);

    AST_CREDIT_CAP: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(MAX)); // R5
    AST_NO_TAKE_DRY: assert property (@(posedge clk) disable iff (rst)
        take |-> cnt_q != '0); // R5
endmodule

// File: rtl/tdm_link_sched.sv
module tdm_link_sched
    import tdm_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int FRAME   = 10,
    parameter int DEPTH   = 4,
    parameter int CREDITS = 4,
    parameter int IDLE_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [FRAME-1:0]  slot_map,
    input  logic              hi_valid,
    input  logic [DATA_W-1:0] hi_data,
    output logic              hi_ready,
    input  logic              lo_valid,
    input  logic [DATA_W-1:0] lo_data,
    output logic              lo_ready,
    input  logic              hi_credit,
    input  logic              lo_credit,
    output logic              link_valid,
    output logic              link_lo,
    output logic [DATA_W-1:0] link_data,
    output logic [IDLE_W-1:0] hi_idle,
    output logic [IDLE_W-1:0] lo_idle
);
    localparam int SW = $clog2(FRAME);

    dom_e           owner;
    logic [SW-1:0]  slot;

    logic              in_valid [NUM_DOM];
    logic [DATA_W-1:0] in_data  [NUM_DOM];
    logic              cr_ret   [NUM_DOM];
    logic              full     [NUM_DOM];
    logic              empty    [NUM_DOM];
    logic              cr_ok    [NUM_DOM];
    logic              grant    [NUM_DOM];
    logic [DATA_W-1:0] head     [NUM_DOM];
    logic [IDLE_W-1:0] idle_q   [NUM_DOM];

    beat_hdr_t         hdr_q;
    logic [DATA_W-1:0] data_q;

    assign in_valid[0] = hi_valid;
    assign in_valid[1] = lo_valid;
    assign in_data[0]  = hi_data;
    assign in_data[1]  = lo_data;
    assign cr_ret[0]   = hi_credit;
    assign cr_ret[1]   = lo_credit;

    tdm_slot_table #(.FRAME(FRAME)) u_table (
        .clk    (clk),
        .rst    (rst),
        .map_in (slot_map),
        .owner  (owner),
        .slot   (slot)
    );

    for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
        logic owns;
        assign owns     = (owner == dom_e'(d));
        assign grant[d] = owns && !empty[d] && cr_ok[d];

        tdm_vc_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_fifo (
            .clk   (clk),
            .rst   (rst),
            .push  (in_valid[d] && !full[d]),
            .din   (in_data[d]),
            .pop   (grant[d]),
            .dout  (head[d]),
            .full  (full[d]),
            .empty (empty[d])
        );

        tdm_credit_ctr #(.MAX(CREDITS)) u_credit (
            .clk  (clk),
            .rst  (rst),
            .take (grant[d]),
            .ret  (cr_ret[d]),
            .ok   (cr_ok[d])
        );

        always_ff @(posedge clk) begin
            if (rst)                    idle_q[d] <= '0;
            else if (owns && !grant[d]) idle_q[d] <= idle_q[d] + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hdr_q  <= '{valid: 1'b0, dom: DOM_HI};
            data_q <= '0;
        end else begin
            hdr_q.valid <= grant[0] || grant[1];
            hdr_q.dom   <= owner;
            if (grant[0] || grant[1])
                data_q <= (owner == DOM_LO) ? head[1] : head[0];
        end
    end

    assign hi_ready   = !full[0];
    assign lo_ready   = !full[1];
    assign link_valid = hdr_q.valid;
    assign link_lo    = (hdr_q.dom == DOM_LO);
    assign link_data  = data_q;
    assign hi_idle    = idle_q[0];
    assign lo_idle    = idle_q[1];

    AST_LINK_OWNER: assert property (@(posedge clk) disable iff (rst)
        link_valid |-> (link_lo == $past(owner == DOM_LO))); // R3
    AST_LO_IDLE_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (lo_idle != $past(lo_idle)) |-> (!link_valid && link_lo)); // R8
    AST_HI_IDLE_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (hi_idle != $past(hi_idle)) |-> (!link_valid && !link_lo)); // R4
    AST_ONE_IDLE_BUMP: assert property (@(posedge clk) disable iff (rst)
        !((hi_idle != $past(hi_idle)) && (lo_idle != $past(lo_idle)))); // R8
endmodule

// File: tb/tb_tdm_link_sched.sv
module tb_tdm_link_sched;
    localparam int DW = 16, FR = 10, DP = 4, CR = 4, IW = 16;
    localparam logic [FR-1:0] MAP_DEF = 10'b0010010010;

    logic clk = 0, rst = 1;
    logic [FR-1:0] slot_map = MAP_DEF;
    logic hi_valid = 0, lo_valid = 0, hi_credit = 0, lo_credit = 0;
    logic [DW-1:0] hi_data = '0, lo_data = '0;
    logic hi_ready, lo_ready, link_valid, link_lo;
    logic [DW-1:0] link_data;
    logic [IW-1:0] hi_idle, lo_idle;

    always #4 clk = ~clk;

    tdm_link_sched #(.DATA_W(DW), .FRAME(FR), .DEPTH(DP), .CREDITS(CR), .IDLE_W(IW)) dut (
        .clk(clk), .rst(rst), .slot_map(slot_map),
        .hi_valid(hi_valid), .hi_data(hi_data), .hi_ready(hi_ready),
        .lo_valid(lo_valid), .lo_data(lo_data), .lo_ready(lo_ready),
        .hi_credit(hi_credit), .lo_credit(lo_credit),
        .link_valid(link_valid), .link_lo(link_lo), .link_data(link_data),
        .hi_idle(hi_idle), .lo_idle(lo_idle));

    int checks = 0, errors = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // stimulus controls
    int h_left = 0, l_left = 0, h_acc = 0, l_acc = 0;
    bit auto_h = 1, auto_l = 1, man_h = 0, man_l = 0;
    int cyc = 0, h_seen = 0, l_seen = 0;
    int rec_on = 0, rec_n = 0;
    int rec_t [16];

    // cycle model built from the requirements
    logic [FR-1:0] m_map;
    int m_slot;
    logic [DW-1:0] hq[$], lq[$];
    int m_hcr, m_lcr;
    bit e_valid, e_lo;
    logic [DW-1:0] e_data;
    int e_hidle, e_lidle;

    always @(posedge clk) begin
        if (rst) begin
            m_map = slot_map; m_slot = 0; hq.delete(); lq.delete();
            m_hcr = CR; m_lcr = CR; e_valid = 0; e_lo = 0;
            e_hidle = 0; e_lidle = 0; cyc = 0;
        end else begin
            bit lo_own, g, push_h, push_l;
            cyc++;
            lo_own = m_map[m_slot];
            push_h = hi_valid && (hq.size() < DP);
            push_l = lo_valid && (lq.size() < DP);
            g = lo_own ? (lq.size() > 0 && m_lcr > 0) : (hq.size() > 0 && m_hcr > 0);
            e_valid = g; e_lo = lo_own;
            if (g) begin
                if (lo_own) begin e_data = lq.pop_front(); m_lcr--; end
                else        begin e_data = hq.pop_front(); m_hcr--; end
            end else if (lo_own) e_lidle++;
            else e_hidle++;
            m_hcr += int'(hi_credit); m_lcr += int'(lo_credit);
            if (push_h) begin hq.push_back(hi_data); h_acc++; h_left--; end
            if (push_l) begin lq.push_back(lo_data); l_acc++; l_left--; end
            m_slot = (m_slot == FR - 1) ? 0 : m_slot + 1;
        end
    end

    // input drive and scoreboard, half a cycle from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            chk(link_valid == e_valid, "R3/R4/R10 link_valid", link_valid, e_valid);
            if (link_valid && e_valid) begin
                chk(link_lo == e_lo, "R3 link_lo", link_lo, e_lo);
                chk(link_data == e_data, "R7 link_data", link_data, e_data);
            end
            chk(hi_idle == IW'(e_hidle), "R8 hi_idle", hi_idle, e_hidle);
            chk(lo_idle == IW'(e_lidle), "R8 lo_idle", lo_idle, e_lidle);
            if (link_valid && link_lo) begin
                l_seen++;
                if (rec_on != 0 && rec_n < 16) begin rec_t[rec_n] = cyc; rec_n++; end
            end
            if (link_valid && !link_lo) h_seen++;
        end
        hi_valid  = (h_left > 0);
        hi_data   = DW'(16'h1000 + h_acc);
        lo_valid  = (l_left > 0);
        lo_data   = DW'(16'h2000 + l_acc);
        hi_credit = (auto_h && link_valid && !link_lo) || man_h;
        lo_credit = (auto_l && link_valid && link_lo) || man_l;
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic do_reset(input logic [FR-1:0] m);
        @(posedge clk); #1;
        rst = 1; slot_map = m; h_left = 0; l_left = 0; h_acc = 0; l_acc = 0;
        auto_h = 1; auto_l = 1; man_h = 0; man_l = 0;
        wait_cyc(2);
        rst = 0; h_seen = 0; l_seen = 0;
    endtask

    task automatic t_reset;
        @(posedge clk); #1; rst = 1; slot_map = MAP_DEF;
        wait_cyc(2);
        chk(link_valid == 0, "R1 link_valid in reset", link_valid, 0);
        chk(hi_idle == 0 && lo_idle == 0, "R1 idle counters in reset", hi_idle + lo_idle, 0);
        chk(hi_ready && lo_ready, "R1 ready in reset", {hi_ready, lo_ready}, 3);
        rst = 0;
    endtask

    task automatic t_idle_frame;
        int eh = 0, el = 0;
        do_reset(MAP_DEF);
        wait_cyc(23);
        for (int s = 0; s < 23; s++) if (MAP_DEF[s % FR]) el++; else eh++;
        chk(hi_idle == IW'(eh), "R2 R8 high idle after 23 slots", hi_idle, eh);
        chk(lo_idle == IW'(el), "R2 R8 low idle after 23 slots", lo_idle, el);
        chk(!link_valid, "R4 no traffic no flit", link_valid, 0);
    endtask

    task automatic t_isolation;
        int ta [16];
        int na;
        do_reset(MAP_DEF); rec_n = 0; rec_on = 1; l_left = 8;
        wait_cyc(60);
        na = rec_n; for (int i = 0; i < 16; i++) ta[i] = rec_t[i];
        do_reset(MAP_DEF); rec_n = 0; l_left = 8; h_left = 1000;
        wait_cyc(60);
        rec_on = 0; h_left = 0;
        chk(na == 8, "R9 low flits delivered, quiet run", na, 8);
        chk(rec_n == na, "R9 low flit count under high flood", rec_n, na);
        for (int i = 0; i < 8; i++)
            chk(rec_t[i] == ta[i], "R9 low delivery cycle", rec_t[i], ta[i]);
        chk(h_seen > 0, "R3 high domain used its slots", h_seen, 1);
    endtask

    task automatic t_credit;
        do_reset(MAP_DEF); auto_l = 0; l_left = 6;
        wait_cyc(40);
        chk(l_seen == CR, "R5 low stops when credits run out", l_seen, CR);
        man_l = 1; wait_cyc(2); man_l = 0;
        wait_cyc(20);
        chk(l_seen == 6, "R5 returned credits resume sending", l_seen, 6);
    endtask

    task automatic t_backpressure;
        do_reset(MAP_DEF); auto_h = 0; h_left = 20;
        wait_cyc(40);
        chk(h_seen == CR, "R5 high sent only its credits", h_seen, CR);
        chk(!hi_ready, "R6 high ready low when buffer full", hi_ready, 0);
        chk(lo_ready, "R6 low ready unaffected", lo_ready, 1);
        l_left = 3;
        wait_cyc(20);
        chk(l_seen == 3, "R6 low traffic flows beside full high", l_seen, 3);
        chk(!hi_ready, "R6 high still held", hi_ready, 0);
    endtask

    task automatic t_all_high_map;
        do_reset('0); l_left = 6; h_left = 5;
        wait_cyc(30);
        chk(l_seen == 0, "R2 R4 low never sends without owned slots", l_seen, 0);
        chk(!lo_ready, "R6 low buffer fills to DEPTH", lo_ready, 0);
        chk(lo_idle == 0, "R8 no low idle without owned slots", lo_idle, 0);
        chk(h_seen == 5, "R3 high uses every slot", h_seen, 5);
    endtask

    task automatic t_alt_map;
        do_reset(10'b1010101010); l_left = 5; h_left = 5;
        wait_cyc(30);
        chk(l_seen == 5 && h_seen == 5, "R2 R7 alternating map delivers both", l_seen * 10 + h_seen, 55);
    endtask

    initial begin
        t_reset();
        t_idle_frame();
        t_isolation();
        t_credit();
        t_backpressure();
        t_all_high_map();
        t_alt_map();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #160000;
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule